// File: doc/BRIEF.md
# Simultaneous-Mode DAC Word Formatter

This block takes a two-channel serial audio stream (bit clock, word select, serial data) and turns it into the form needed by a dual-channel DAC that runs with a stopped clock and loads both channels together. The block takes each left word and delays it by exactly one channel slot, so it lines up with the right word that follows it. Both 16-bit words then leave together, MSB first, on two separate data lines. A gated DAC clock toggles only while those 16 bits are valid. After the 16th bit, one latch strobe, shared by both channels, tells the DAC to transfer the words.

The block has two optional features. In differential mode, each channel gets a second line that carries the ones' complement of its main line. A mute input forces every data line low. A select input chooses between two slot lengths. In 64Fs framing each slot is 32 bit clocks and the delay is tapped at stage 32. In 48Fs framing each slot is 24 bit clocks and the delay is tapped at stage 24. All logic runs on the input bit clock.

A small state machine sequences each frame. It has four states:
- HUNT is the state after reset. It moves to WAIT on the first falling edge of word select (the start of a left slot).
- WAIT moves to SHIFT on a rising edge of word select (the start of a right slot).
- SHIFT lasts 16 cycles and then moves to LATCH.
- LATCH lasts one cycle and then returns to WAIT.

Top module: `simul_dac_formatter`

## Requirements
- R1: While rst_n is low, every data line, latch_en and dac_clk are low.
- R2: For each frame, data_l_p carries the 16-bit left word received in the preceding left slot, and data_r_p carries the right word of the current right slot. Both are MSB first and are captured on the 16 rising edges of dac_clk. The word's MSB is the bit that follows the word-select change by one bit clock. In the default framing a slot is 32 bit clocks.
- R3: dac_clk has exactly 16 rising edges per frame. Each one occurs at a falling edge of bclk, in the middle of a data bit. At all other times dac_clk is low.
- R4: latch_en is high for exactly one bclk period, once per frame. It rises at the 17th bclk rising edge after the edge that first samples ws high, and dac_clk stays low while it is high.
- R5: With fs48_sel high, a slot is 24 bit clocks and the left word is delayed by 24 bit clocks. R2 to R4 still hold.
- R6: With diff_en high, data_l_n and data_r_n carry the bitwise complement of data_l_p and data_r_p during the 16-bit window. With diff_en low, they stay low.
- R7: When mute is high at a bclk rising edge, all four data lines are low for the following bclk period. dac_clk and latch_en still run.
- R8: Outside the 16-bit window, all four data lines are low. Bits 17 and beyond of a slot have no effect on any output.
- R9: After reset, no dac_clk edge and no latch_en pulse occur until ws has been sampled low, that is, until a left slot has begun.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bclk | input | 1 | Input serial bit clock; all logic runs on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ws | input | 1 | Word select: low for the left slot, high for the right slot |
| sdata | input | 1 | Serial sample data, MSB first |
| fs48_sel | input | 1 | High selects 24-clock slots, low selects 32-clock slots |
| diff_en | input | 1 | High enables the complementary data lines |
| mute | input | 1 | High forces all data lines low |
| dac_clk | output | 1 | Gated DAC bit clock, 16 pulses per frame |
| data_l_p | output | 1 | Left channel data, positive line |
| data_l_n | output | 1 | Left channel data, complementary line |
| data_r_p | output | 1 | Right channel data, positive line |
| data_r_n | output | 1 | Right channel data, complementary line |
| latch_en | output | 1 | Shared word-latch strobe, one bclk period long |

## Verification
The assertions assume that ws toggles once per slot, with slots of the selected length, and that after reset the stream starts on a slot boundary. They also assume fs48_sel changes only while reset is held. The stimulus enforces these assumptions:
- Every frame is built from whole slots with the correct word-select change one bit before each MSB.
- The slot length is switched only across a reset.
- Mute and differential mode are changed only at the start of a left slot, when no output window is open.

The padding bits of every slot carry a mix of patterns, so they can exercise R8.

// File: rtl/sdf_pkg.sv
`timescale 1ns/1ps
package sdf_pkg;
    // Frame sequencing states of the formatter
    typedef enum logic [1:0] {
        ST_HUNT  = 2'd0,
        ST_WAIT  = 2'd1,
        ST_SHIFT = 2'd2,
        ST_LATCH = 2'd3
    } seq_state_e;

    localparam int NUM_CH = 2;
endpackage

// File: rtl/sdf_slot_delay.sv
`timescale 1ns/1ps
// Serial delay line one channel slot long; tap chosen by the framing select.
module sdf_slot_delay #(
    parameter int SLOT_LONG  = 32,
    parameter int SLOT_SHORT = 24
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    input  logic short_sel,
    output logic tap
);
    logic [SLOT_LONG-1:0] stage;

    // stage[j] holds the input sampled j+1 edges ago (after the update)
    genvar g;
    generate
        for (g = 0; g < SLOT_LONG; g++) begin : g_stage
            if (g == 0) begin : g_head
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage[g] <= 1'b0;
                    else        stage[g] <= din;
                end
            end else begin : g_body
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage[g] <= 1'b0;
                    else        stage[g] <= stage[g-1];
                end
            end
        end

        if (SLOT_SHORT < SLOT_LONG) begin : g_two_taps
            assign tap = short_sel ? stage[SLOT_SHORT-1] : stage[SLOT_LONG-1];
        end else begin : g_one_tap
            logic unused_sel;
            assign unused_sel = short_sel;
            assign tap = stage[SLOT_LONG-1];
        end
    endgenerate
endmodule

// File: rtl/sdf_sequencer.sv
`timescale 1ns/1ps
// Frame state machine: finds the right-slot start, opens a 16-bit window,
// then issues one latch cycle.
module sdf_sequencer
    import sdf_pkg::*;
#(
    parameter int WORD_BITS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ws,
    output logic load,
    output logic win_q,
    output logic le_q
);
    localparam int CW = (WORD_BITS > 1) ? $clog2(WORD_BITS) : 1;
    localparam logic [CW-1:0] LAST_BIT = CW'(WORD_BITS - 1);

    seq_state_e     state, state_nx;
    logic           ws_d;
    logic [CW-1:0]  bit_cnt;
    logic           ws_rise, ws_fall;

    // ws_d resets high so that a stream starting low counts as a left-slot start
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ws_d <= 1'b1;
        else        ws_d <= ws;
    end

    assign ws_rise = ws & ~ws_d;
    assign ws_fall = ~ws & ws_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_HUNT;
        else        state <= state_nx;
    end

    // Transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_HUNT:  if (ws_fall)              state_nx = ST_WAIT;
            ST_WAIT:  if (ws_rise)              state_nx = ST_SHIFT;
            ST_SHIFT: if (bit_cnt == LAST_BIT)  state_nx = ST_LATCH;
            ST_LATCH:                           state_nx = ST_WAIT;
        endcase
    end

    // Bit position inside the window
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 bit_cnt <= '0;
        else if (state != ST_SHIFT) bit_cnt <= '0;
        else                        bit_cnt <= bit_cnt + 1'b1;
    end

    // Outputs: load is used at the same edge, window and strobe are registered
    assign load = (state == ST_SHIFT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_q <= 1'b0;
            le_q  <= 1'b0;
        end else begin
            win_q <= (state == ST_SHIFT);
            le_q  <= (state == ST_LATCH);
        end
    end
endmodule

// File: rtl/sdf_output_stage.sv
`timescale 1ns/1ps
// Registered data lines for both channels with mute and complement lines.
module sdf_output_stage
    import sdf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              diff_en,
    input  logic              mute,
    input  logic [NUM_CH-1:0] bit_in,
    output logic [NUM_CH-1:0] pos_q,
    output logic [NUM_CH-1:0] neg_q
);
    genvar ch;
    generate
        for (ch = 0; ch < NUM_CH; ch++) begin : g_ch
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    pos_q[ch] <= 1'b0;
                    neg_q[ch] <= 1'b0;
                end else if (load && !mute) begin
                    pos_q[ch] <= bit_in[ch];
                    neg_q[ch] <= diff_en & ~bit_in[ch];
                end else begin
                    pos_q[ch] <= 1'b0;
                    neg_q[ch] <= 1'b0;
                end
            end
        end
    endgenerate
endmodule

// File: rtl/sdf_clock_gate.sv
`timescale 1ns/1ps
// Gated DAC clock: the enable changes just after a rising bclk edge, while
// the inverted clock is already low, so no partial pulse can appear.
module sdf_clock_gate (
    input  logic clk,
    input  logic en_q,
    output logic gclk
);
    assign gclk = en_q & ~clk;
endmodule

// File: rtl/simul_dac_formatter.sv
`timescale 1ns/1ps
module simul_dac_formatter
    import sdf_pkg::*;
#(
    parameter int WORD_BITS  = 16,
    parameter int SLOT_LONG  = 32,
    parameter int SLOT_SHORT = 24
) (
    input  logic bclk,
    input  logic rst_n,
    input  logic ws,
    input  logic sdata,
    input  logic fs48_sel,
    input  logic diff_en,
    input  logic mute,
    output logic dac_clk,
    output logic data_l_p,
    output logic data_l_n,
    output logic data_r_p,
    output logic data_r_n,
    output logic latch_en
);
    logic              load;
    logic              dac_en;
    logic              left_tap;
    logic [NUM_CH-1:0] bits;
    logic [NUM_CH-1:0] pos;
    logic [NUM_CH-1:0] neg;

    sdf_slot_delay #(
        .SLOT_LONG (SLOT_LONG),
        .SLOT_SHORT(SLOT_SHORT)
    ) u_delay (
        .clk      (bclk),
        .rst_n    (rst_n),
        .din      (sdata),
        .short_sel(fs48_sel),
        .tap      (left_tap)
    );

    sdf_sequencer #(
        .WORD_BITS(WORD_BITS)
    ) u_seq (
        .clk  (bclk),
        .rst_n(rst_n),
        .ws   (ws),
        .load (load),
        .win_q(dac_en),
        .le_q (latch_en)
    );

    // channel 0 = left (delayed), channel 1 = right (live)
    assign bits = {sdata, left_tap};

    sdf_output_stage u_out (
        .clk    (bclk),
        .rst_n  (rst_n),
        .load   (load),
        .diff_en(diff_en),
        .mute   (mute),
        .bit_in (bits),
        .pos_q  (pos),
        .neg_q  (neg)
    );

    sdf_clock_gate u_gate (
        .clk (bclk),
        .en_q(dac_en),
        .gclk(dac_clk)
    );

    assign data_l_p = pos[0];
    assign data_l_n = neg[0];
    assign data_r_p = pos[1];
    assign data_r_n = neg[1];
endmodule

// File: rtl/simul_dac_formatter_chk.sv
`timescale 1ns/1ps
module simul_dac_formatter_chk #(
    parameter int WORD_BITS = 16
) (
    input logic bclk,
    input logic rst_n,
    input logic mute,
    input logic diff_en,
    input logic win,
    input logic latch_en,
    input logic data_l_p,
    input logic data_l_n,
    input logic data_r_p,
    input logic data_r_n
);
    localparam int CNTW = $clog2(WORD_BITS + 1) + 1;

    logic [CNTW-1:0] win_cnt;

    always_ff @(posedge bclk or negedge rst_n) begin
        if (!rst_n)        win_cnt <= '0;
        else if (latch_en) win_cnt <= '0;
        else if (win)      win_cnt <= win_cnt + 1'b1;
    end

    assert_le_one_cycle_R4: assert property (@(posedge bclk) disable iff (!rst_n)
        latch_en |=> !latch_en);

    assert_clk_stopped_R4: assert property (@(posedge bclk) disable iff (!rst_n)
        latch_en |-> !win);

    assert_le_follows_window_R4: assert property (@(posedge bclk) disable iff (!rst_n)
        $fell(win) |-> latch_en);

    assert_word_clocks_R3: assert property (@(posedge bclk) disable iff (!rst_n)
        latch_en |-> (win_cnt == CNTW'(WORD_BITS)));

    assert_mute_silence_R7: assert property (@(posedge bclk) disable iff (!rst_n)
        $past(mute) |-> (!data_l_p && !data_l_n && !data_r_p && !data_r_n));

    assert_idle_quiet_R8: assert property (@(posedge bclk) disable iff (!rst_n)
        !win |-> (!data_l_p && !data_l_n && !data_r_p && !data_r_n));

    assert_complement_R6: assert property (@(posedge bclk) disable iff (!rst_n)
        (win && $past(diff_en) && !$past(mute)) |->
            ((data_l_n == !data_l_p) && (data_r_n == !data_r_p)));

    assert_single_ended_R6: assert property (@(posedge bclk) disable iff (!rst_n)
        !$past(diff_en) |-> (!data_l_n && !data_r_n));
endmodule

bind simul_dac_formatter simul_dac_formatter_chk #(
    .WORD_BITS(WORD_BITS)
) u_chk (
    .bclk    (bclk),
    .rst_n   (rst_n),
    .mute    (mute),
    .diff_en (diff_en),
    .win     (dac_en),
    .latch_en(latch_en),
    .data_l_p(data_l_p),
    .data_l_n(data_l_n),
    .data_r_p(data_r_p),
    .data_r_n(data_r_n)
);

// File: tb/simul_dac_formatter_bench.sv
`timescale 1ns/1ps
module simul_dac_formatter_bench;
    logic bclk = 1'b0;
    logic rst_n = 1'b0;
    logic ws = 1'b1, sdata = 1'b0, fs48_sel = 1'b0, diff_en = 1'b0, mute = 1'b0;
    logic dac_clk, data_l_p, data_l_n, data_r_p, data_r_n, latch_en;

    always #2 bclk = ~bclk;   // 250 MHz

    simul_dac_formatter u_simul_dac_formatter (
        .bclk(bclk), .rst_n(rst_n), .ws(ws), .sdata(sdata),
        .fs48_sel(fs48_sel), .diff_en(diff_en), .mute(mute),
        .dac_clk(dac_clk), .data_l_p(data_l_p), .data_l_n(data_l_n),
        .data_r_p(data_r_p), .data_r_n(data_r_n), .latch_en(latch_en)
    );

    int checks = 0, fails = 0;
    int slot_len = 32;
    logic [15:0] exp_l [0:255];
    logic [15:0] exp_r [0:255];
    bit          exp_m [0:255];
    bit          exp_d [0:255];
    int wr = 0, rd = 0;
    longint t_rise = 0;
    bit done = 1'b0;

    logic [15:0] cap_lp = '0, cap_ln = '0, cap_rp = '0, cap_rn = '0;
    int nclk = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    function automatic logic [15:0] pat(input int i);
        if (i < 16)       return 16'(1) << i;
        else if (i == 16) return 16'h8000;
        else if (i == 17) return 16'h7FFF;
        else if (i == 18) return 16'hFFFF;
        else if (i == 19) return 16'h0000;
        else              return 16'((i * 40503) ^ (i << 7) ^ 16'hA5C3);
    endfunction

    // one slot: ws changes at period 0, MSB at period 1, padding after bit 16
    task automatic drive_slot(input bit wsv, input logic [15:0] w);
        for (int j = 0; j < slot_len; j++) begin
            @(negedge bclk);
            ws = wsv;
            if (wsv && j == 0) t_rise = $time;
            if (j >= 1 && j <= 16) sdata = w[16-j];
            else                   sdata = j[0];   // padding noise, must be ignored (R8)
        end
    endtask

    task automatic send_frame(input logic [15:0] l, input logic [15:0] r, input bit m, input bit d);
        @(negedge bclk);
        mute = m;
        diff_en = d;
        exp_l[wr] = l; exp_r[wr] = r; exp_m[wr] = m; exp_d[wr] = d;
        wr++;
        ws = 1'b0;
        sdata = 1'b0;
        for (int j = 1; j < slot_len; j++) begin
            @(negedge bclk);
            sdata = (j >= 1 && j <= 16) ? l[16-j] : ~j[0];
        end
        drive_slot(1'b1, r);
    endtask

    always @(posedge dac_clk) begin
        cap_lp = {cap_lp[14:0], data_l_p};
        cap_ln = {cap_ln[14:0], data_l_n};
        cap_rp = {cap_rp[14:0], data_r_p};
        cap_rn = {cap_rn[14:0], data_r_n};
        nclk++;
    end

    always @(negedge bclk) begin
        #1;
        if (rst_n && latch_en) begin
            logic [15:0] el, er, eln, ern;
            string tg;
            tg = fs48_sel ? "R5" : "R2";
            el  = exp_m[rd] ? 16'h0 : exp_l[rd];
            er  = exp_m[rd] ? 16'h0 : exp_r[rd];
            eln = (exp_d[rd] && !exp_m[rd]) ? ~el : 16'h0;
            ern = (exp_d[rd] && !exp_m[rd]) ? ~er : 16'h0;
            if (exp_m[rd]) begin
                chk("R7 muted left", cap_lp, el);
                chk("R7 muted right", cap_rp, er);
            end else begin
                chk({tg, " left word"}, cap_lp, el);
                chk({tg, " right word"}, cap_rp, er);
            end
            chk("R6 left complement line", cap_ln, eln);
            chk("R6 right complement line", cap_rn, ern);
            chk("R3 dac_clk edges per frame", nclk, 16);
            chk("R4 dac_clk low during latch", dac_clk, 0);
            chk("R4 latch timing", 32'($time - t_rise), 32'd73);
            nclk = 0;
            rd++;
        end else if (rst_n && !dac_clk) begin
            chk("R8 idle lines low", {data_l_p, data_l_n, data_r_p, data_r_n}, 4'b0000);
        end
    end

    task automatic do_reset(input bit sel48);
        rst_n = 1'b0;
        ws = 1'b1;
        sdata = 1'b0;
        fs48_sel = sel48;
        slot_len = sel48 ? 24 : 32;
        repeat (5) @(negedge bclk);
        #1;
        chk("R1 reset data lines", {data_l_p, data_l_n, data_r_p, data_r_n}, 4'b0000);
        chk("R1 reset latch_en", latch_en, 0);
        chk("R1 reset dac_clk", dac_clk, 0);
        @(negedge bclk);
        rst_n = 1'b1;
        nclk = 0;
    endtask

    initial begin
        do_reset(1'b0);
        // right slot with no preceding left slot: must produce nothing (R9)
        drive_slot(1'b1, 16'hFFFF);
        drive_slot(1'b1, 16'hAAAA);
        chk("R9 no dac_clk before left slot", nclk, 0);
        chk("R9 no latch before left slot", rd, 0);
        for (int d = 0; d < 2; d++)
            for (int i = 0; i < 24; i++)
                send_frame(pat(i), pat(i + 7) ^ 16'h5A5A, (i % 11) == 5, d[0]);
        repeat (4) @(negedge bclk);
        chk("R2 all frames latched", rd, wr);

        do_reset(1'b1);
        for (int d = 0; d < 2; d++)
            for (int i = 0; i < 22; i++)
                send_frame(pat(i + 3), pat(i) ^ 16'h33CC, (i % 9) == 4, d[0]);
        repeat (4) @(negedge bclk);
        chk("R5 all frames latched", rd, wr);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge bclk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", rd, wr);
            $display("[TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    end
endmodule